// File: doc/BRIEF.md
# E1 Transmit Frame and Multiframe Assembler

This block builds the serial 2048 kbit/s transmit stream of a 30-channel E1 trunk. It runs at the bit clock and keeps its own bit, timeslot and frame counters. While the current slot is still being sent, it asks for the next timeslot's byte. It fills the two overhead slots itself and shifts everything out one bit per clock, first bit first. Timeslot 0 alternates between a frame alignment word in even frames and a service word in odd frames. The service word carries the remote alarm and five national bits. Timeslot 16 follows a 16-frame signalling multiframe: frame 0 holds the alignment code and the multiframe alarm, and each later frame holds two 4-bit signalling nibbles read from an external signalling memory.

An upstream buffer answers the per-slot request strobe by placing the byte on the data input. A signalling memory with one cycle of read latency answers the read port. When CRC framing is enabled, a separate CRC unit supplies bit 1 of timeslot 0. In common channel mode, timeslot 16 carries user data from the input like any other channel, and no signalling reads are made. An active-low multiframe alignment input restarts the counters at frame 0. When that input is held high, the block keeps its own multiframe timing.

Top module: `e1_tx_framer`

## Requirements
- R1: During and just after reset, the counters sit on the last bit of frame 15, timeslot 31. In this state `tx_bit` is 0, `ts_req` is 1, `req_ts` is 0 and `sig_rd` is 0. The first clock edge after reset starts frame 0, timeslot 0.
- R2: A frame is 32 slots of 8 bits and 16 frames form a multiframe. Bits go out one per clock, bit 1 (the byte MSB) first. `ts_req` is high exactly during the last bit of each slot, and then `req_ts` gives the number of the next slot. The byte on `in_data` at that clock edge is sent in the next slot.
- R3: Slots 1–15 and 17–31 send `in_data` unchanged. The value on `in_data` for slot 0, and for slot 16 when common channel mode is off, has no effect on the output.
- R4: In even frames, slot 0 is {b1, 0011011}, with b1 sent first.
- R5: In odd frames, slot 0 is {b1, 1, `rai`, `nat_bits[4:0]`}, with `nat_bits[4]` sent fourth.
- R6: b1 equals `crc_bit` when `crc_en` is 1, and 1 otherwise. Both inputs are sampled at the edge that loads slot 0.
- R7: In frame 0 with common channel mode off, slot 16 is {0000, 1, `mf_rai`, 1, 1}.
- R8: In frame n (1–15) with common channel mode off, slot 16 is {sig(n), sig(n+15)}. During slot 15 of that frame, `sig_rd` is high for bits 1 and 2, with `sig_addr` n and then n+15. `sig_data` returns each nibble one clock after its address.
- R9: With `ccs_en` high, slot 16 sends `in_data` in every frame and `sig_rd` stays low.
- R10: A clock edge that sees `mf_align_n` low puts the counters at frame 0, slot 0, bit 1. While it stays low, `tx_bit` holds b1. After it rises, the frame continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_align_n | input | 1 | Active-low multiframe restart; held high for free-running timing |
| ccs_en | input | 1 | Common channel mode: slot 16 carries user data |
| in_data | input | 8 | Byte for the slot named by `req_ts` |
| ts_req | output | 1 | Request for the next slot's byte |
| req_ts | output | 5 | Number of the requested slot |
| crc_en | input | 1 | Take bit 1 of slot 0 from `crc_bit` |
| crc_bit | input | 1 | Bit 1 value from the CRC unit |
| rai | input | 1 | Remote alarm bit for odd-frame slot 0 |
| nat_bits | input | 5 | National bits for odd-frame slot 0 |
| mf_rai | input | 1 | Multiframe alarm bit for frame 0, slot 16 |
| sig_rd | output | 1 | Signalling memory read strobe |
| sig_addr | output | 5 | Signalling channel number, 1 to 30 |
| sig_data | input | 4 | ABCD nibble, one clock after the read |
| tx_bit | output | 1 | Serial transmit stream |

## Verification
The bench builds the block with the default 32 slots and 16 frames, so a full multiframe takes 4096 clocks. Each scenario therefore runs through every signalling frame, both counter wraps and both slot 0 variants within a few thousand cycles. A model in the bench rebuilds every expected slot byte from the control inputs and a signalling table. It also checks the memory read timing, and it checks restarts both in mid-slot and with the restart held low.

// File: rtl/e1f_pkg.sv
package e1f_pkg;

  localparam int TS_BITS = 8;
  localparam int NAT_W   = TS_BITS - 3;
  localparam int NIB_W   = TS_BITS / 2;

  localparam logic [TS_BITS-2:0] FAS_TAIL = 7'b0011011;

  typedef enum logic [1:0] {
    SK_TS0  = 2'd0,
    SK_SIG  = 2'd1,
    SK_CHAN = 2'd2
  } slot_kind_e;

  function automatic logic [TS_BITS-1:0] fas_word(input logic b1);
    return {b1, FAS_TAIL};
  endfunction

  function automatic logic [TS_BITS-1:0] nfas_word(input logic b1, input logic alarm,
                                                   input logic [NAT_W-1:0] nat);
    return {b1, 1'b1, alarm, nat};
  endfunction

  function automatic logic [TS_BITS-1:0] mfas_word(input logic y);
    return {{NIB_W{1'b0}}, 1'b1, y, 1'b1, 1'b1};
  endfunction

  function automatic logic [TS_BITS-1:0] cas_word(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/e1f_pos_counter.sv
module e1f_pos_counter #(
  parameter int N_TS  = 32,
  parameter int N_FRM = 16,
  localparam int BIT_W = $clog2(e1f_pkg::TS_BITS),
  localparam int TS_W  = $clog2(N_TS),
  localparam int FRM_W = $clog2(N_FRM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mf_align_n,
  output logic [BIT_W-1:0] cur_bit,
  output logic [TS_W-1:0]  cur_ts,
  output logic [FRM_W-1:0] cur_frm,
  output logic [TS_W-1:0]  nxt_ts,
  output logic [FRM_W-1:0] nxt_frm,
  output logic             slot_load,
  output logic             ts_req
);
  logic [BIT_W-1:0] bit_d;
  logic             last_bit, last_ts, last_frm;

  assign last_bit = cur_bit == BIT_W'(e1f_pkg::TS_BITS - 1);
  assign last_ts  = cur_ts  == TS_W'(N_TS - 1);
  assign last_frm = cur_frm == FRM_W'(N_FRM - 1);

  always_comb begin
    bit_d   = last_bit ? '0 : cur_bit + 1'b1;
    nxt_ts  = last_bit ? (last_ts ? '0 : cur_ts + 1'b1) : cur_ts;
    nxt_frm = (last_bit && last_ts) ? (last_frm ? '0 : cur_frm + 1'b1) : cur_frm;
    if (!mf_align_n) begin
      bit_d   = '0;
      nxt_ts  = '0;
      nxt_frm = '0;
    end
  end

  assign slot_load = last_bit || !mf_align_n;
  assign ts_req    = last_bit && mf_align_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bit <= BIT_W'(e1f_pkg::TS_BITS - 1);
      cur_ts  <= TS_W'(N_TS - 1);
      cur_frm <= FRM_W'(N_FRM - 1);
    end else begin
      cur_bit <= bit_d;
      cur_ts  <= nxt_ts;
      cur_frm <= nxt_frm;
    end
  end
endmodule

// File: rtl/e1f_ts0_gen.sv
module e1f_ts0_gen (
  input  logic                       odd_frame,
  input  logic                       crc_en,
  input  logic                       crc_bit,
  input  logic                       rai,
  input  logic [e1f_pkg::NAT_W-1:0]  nat_bits,
  output logic [e1f_pkg::TS_BITS-1:0] word
);
  logic b1;

  assign b1   = crc_en ? crc_bit : 1'b1;
  assign word = odd_frame ? e1f_pkg::nfas_word(b1, rai, nat_bits) : e1f_pkg::fas_word(b1);
endmodule

// File: rtl/e1f_ts16_gen.sv
module e1f_ts16_gen #(
  parameter int N_TS  = 32,
  parameter int N_FRM = 16,
  localparam int BIT_W    = $clog2(e1f_pkg::TS_BITS),
  localparam int TS_W     = $clog2(N_TS),
  localparam int FRM_W    = $clog2(N_FRM),
  localparam int CH_W     = $clog2(2 * N_FRM - 1),
  localparam int FETCH_TS = N_TS / 2 - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ccs_en,
  input  logic                        mf_rai,
  input  logic [BIT_W-1:0]            cur_bit,
  input  logic [TS_W-1:0]             cur_ts,
  input  logic [FRM_W-1:0]            cur_frm,
  input  logic [FRM_W-1:0]            nxt_frm,
  output logic                        sig_rd,
  output logic [CH_W-1:0]             sig_addr,
  input  logic [e1f_pkg::NIB_W-1:0]   sig_data,
  output logic [e1f_pkg::TS_BITS-1:0] word
);
  logic                      fetch_slot;
  logic [e1f_pkg::NIB_W-1:0] sig_hi_q, sig_lo_q;

  assign fetch_slot = (cur_ts == TS_W'(FETCH_TS)) && (cur_frm != '0) && !ccs_en;
  assign sig_rd     = fetch_slot && (cur_bit < BIT_W'(2));
  assign sig_addr   = CH_W'(cur_frm) + (cur_bit[0] ? CH_W'(N_FRM - 1) : CH_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_hi_q <= '0;
      sig_lo_q <= '0;
    end else if (fetch_slot) begin
      if (cur_bit == BIT_W'(1)) sig_hi_q <= sig_data;
      if (cur_bit == BIT_W'(2)) sig_lo_q <= sig_data;
    end
  end

  assign word = (nxt_frm == '0) ? e1f_pkg::mfas_word(mf_rai)
                                : e1f_pkg::cas_word(sig_hi_q, sig_lo_q);
endmodule

// File: rtl/e1f_shifter.sv
module e1f_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_in,
  output logic         ser_out
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= word_in;
    else           sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign ser_out = sh_q[W-1];
endmodule

// File: rtl/e1_tx_framer.sv
module e1_tx_framer #(
  parameter int N_TS  = 32,
  parameter int N_FRM = 16,
  localparam int TS_W = $clog2(N_TS),
  localparam int CH_W = $clog2(2 * N_FRM - 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mf_align_n,
  input  logic                        ccs_en,
  input  logic [e1f_pkg::TS_BITS-1:0] in_data,
  output logic                        ts_req,
  output logic [TS_W-1:0]             req_ts,
  input  logic                        crc_en,
  input  logic                        crc_bit,
  input  logic                        rai,
  input  logic [e1f_pkg::NAT_W-1:0]   nat_bits,
  input  logic                        mf_rai,
  output logic                        sig_rd,
  output logic [CH_W-1:0]             sig_addr,
  input  logic [e1f_pkg::NIB_W-1:0]   sig_data,
  output logic                        tx_bit
);
  import e1f_pkg::*;

  localparam int BIT_W = $clog2(TS_BITS);
  localparam int FRM_W = $clog2(N_FRM);
  localparam int TS16  = N_TS / 2;

  logic [BIT_W-1:0]   cur_bit;
  logic [TS_W-1:0]    cur_ts, nxt_ts;
  logic [FRM_W-1:0]   cur_frm, nxt_frm;
  logic               slot_load;
  logic [TS_BITS-1:0] ts0_word, ts16_word, load_word;
  slot_kind_e         kind;
  logic               ts16_ccs_q;

  e1f_pos_counter #(.N_TS(N_TS), .N_FRM(N_FRM)) u_pos (
    .clk(clk), .rst_n(rst_n), .mf_align_n(mf_align_n),
    .cur_bit(cur_bit), .cur_ts(cur_ts), .cur_frm(cur_frm),
    .nxt_ts(nxt_ts), .nxt_frm(nxt_frm), .slot_load(slot_load), .ts_req(ts_req)
  );

  e1f_ts0_gen u_ts0 (
    .odd_frame(nxt_frm[0]), .crc_en(crc_en), .crc_bit(crc_bit),
    .rai(rai), .nat_bits(nat_bits), .word(ts0_word)
  );

  e1f_ts16_gen #(.N_TS(N_TS), .N_FRM(N_FRM)) u_ts16 (
    .clk(clk), .rst_n(rst_n), .ccs_en(ccs_en), .mf_rai(mf_rai),
    .cur_bit(cur_bit), .cur_ts(cur_ts), .cur_frm(cur_frm), .nxt_frm(nxt_frm),
    .sig_rd(sig_rd), .sig_addr(sig_addr), .sig_data(sig_data), .word(ts16_word)
  );

  assign req_ts = nxt_ts;

  always_comb begin
    if (nxt_ts == '0)                 kind = SK_TS0;
    else if (nxt_ts == TS_W'(TS16))   kind = ccs_en ? SK_CHAN : SK_SIG;
    else                              kind = SK_CHAN;
    unique case (kind)
      SK_TS0:  load_word = ts0_word;
      SK_SIG:  load_word = ts16_word;
      default: load_word = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ts16_ccs_q <= 1'b0;
    else if (slot_load && nxt_ts == TS_W'(TS16)) ts16_ccs_q <= ccs_en;
  end

  e1f_shifter #(.W(TS_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(slot_load), .word_in(load_word), .ser_out(tx_bit)
  );
endmodule

// File: rtl/e1f_checker.sv
module e1f_checker #(
  parameter int N_TS  = 32,
  parameter int N_FRM = 16,
  localparam int BIT_W = $clog2(e1f_pkg::TS_BITS),
  localparam int TS_W  = $clog2(N_TS),
  localparam int FRM_W = $clog2(N_FRM),
  localparam int CH_W  = $clog2(2 * N_FRM - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mf_align_n,
  input logic             tx_bit,
  input logic             ts_req,
  input logic             sig_rd,
  input logic [CH_W-1:0]  sig_addr,
  input logic [BIT_W-1:0] cur_bit,
  input logic [TS_W-1:0]  cur_ts,
  input logic [FRM_W-1:0] cur_frm,
  input logic             ts16_ccs_q
);
  localparam logic [7:0] FAS_REF = {1'b0, e1f_pkg::FAS_TAIL};
  localparam int TS16 = N_TS / 2;

  p_req_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |=> !ts_req);

  p_fas_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ts == '0 && !cur_frm[0] && cur_bit != '0) |-> tx_bit == FAS_REF[3'(7) - cur_bit]);

  p_nfas_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ts == '0 && cur_frm[0] && cur_bit == BIT_W'(1)) |-> tx_bit);

  p_mfas_zeros_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ts == TS_W'(TS16) && cur_frm == '0 && cur_bit < BIT_W'(4) && !ts16_ccs_q) |-> !tx_bit);

  p_sig_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sig_rd) && mf_align_n) |=> sig_addr == $past(sig_addr) + CH_W'(N_FRM - 1));

  p_mf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_align_n |=> (cur_frm == '0 && cur_ts == '0 && cur_bit == '0));
endmodule

bind e1_tx_framer e1f_checker #(.N_TS(N_TS), .N_FRM(N_FRM)) i_chk (
  .clk(clk), .rst_n(rst_n), .mf_align_n(mf_align_n), .tx_bit(tx_bit), .ts_req(ts_req),
  .sig_rd(sig_rd), .sig_addr(sig_addr), .cur_bit(cur_bit), .cur_ts(cur_ts),
  .cur_frm(cur_frm), .ts16_ccs_q(ts16_ccs_q)
);

// File: tb/test_e1_tx_framer.sv
module test_e1_tx_framer;
  localparam int N_TS = 32;
  localparam int N_FRM = 16;
  localparam int MF_CYC = N_TS * 8 * N_FRM;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, mf_align_n, ccs_en, crc_en, crc_bit, rai, mf_rai;
  logic [7:0] in_data;
  logic [4:0] nat;
  logic [3:0] sig_data;
  logic       ts_req, sig_rd, tx_bit;
  logic [4:0] req_ts, sig_addr;
  logic [3:0] sig_mem [0:31];

  int checks = 0, errors = 0, skip = 0;
  bit mon_on = 0;
  int m_bit = 7, m_ts = 31, m_frm = 15;
  logic [7:0] rx = '0;
  logic [7:0] seed = 8'h5A;

  e1_tx_framer i_e1_tx_framer (
    .clk(clk), .rst_n(rst_n), .mf_align_n(mf_align_n), .ccs_en(ccs_en), .in_data(in_data),
    .ts_req(ts_req), .req_ts(req_ts), .crc_en(crc_en), .crc_bit(crc_bit), .rai(rai),
    .nat_bits(nat), .mf_rai(mf_rai), .sig_rd(sig_rd), .sig_addr(sig_addr),
    .sig_data(sig_data), .tx_bit(tx_bit)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(int f, int t);
    return 8'(t * 37 + f * 11 + int'(seed));
  endfunction

  function automatic logic [7:0] exp_byte(int f, int t);
    logic b1;
    b1 = crc_en ? crc_bit : 1'b1;
    if (t == 0) return (f % 2 == 0) ? {b1, 7'b0011011} : {b1, 1'b1, rai, nat};
    if (t == 16) begin
      if (ccs_en) return dat(f, 16);
      if (f == 0) return {4'b0000, 1'b1, mf_rai, 2'b11};
      return {sig_mem[f], sig_mem[f + 15]};
    end
    return dat(f, t);
  endfunction

  function automatic string tag_of(int f, int t);
    if (t == 0) return (f % 2 == 0) ? "R4 R6" : "R5 R6";
    if (t == 16) return ccs_en ? "R9" : ((f == 0) ? "R7" : "R8");
    return "R3";
  endfunction

  // signalling memory, one clock read latency
  always @(posedge clk) if (sig_rd) sig_data <= sig_mem[sig_addr];

  // position model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bit <= 7; m_ts <= 31; m_frm <= 15;
    end else if (!mf_align_n) begin
      m_bit <= 0; m_ts <= 0; m_frm <= 0;
    end else begin
      m_bit <= (m_bit + 1) % 8;
      if (m_bit == 7) begin
        m_ts <= (m_ts + 1) % N_TS;
        if (m_ts == N_TS - 1) m_frm <= (m_frm + 1) % N_FRM;
      end
    end
  end

  // data source answering requests
  always @(negedge clk) begin
    if (ts_req) in_data <= dat((req_ts == 0) ? (m_frm + 1) % N_FRM : m_frm, int'(req_ts));
  end

  // stream monitor
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      rx = {rx[6:0], tx_bit};
      if (m_bit == 7) begin
        chk(ts_req == mf_align_n, "R2 ts_req", ts_req, mf_align_n);
        if (mf_align_n)
          chk(int'(req_ts) == (m_ts + 1) % N_TS, "R2 req_ts", req_ts, (m_ts + 1) % N_TS);
        if (skip > 0) skip--;
        else chk(rx == exp_byte(m_frm, m_ts), tag_of(m_frm, m_ts), rx, exp_byte(m_frm, m_ts));
      end
      if (m_ts == 15 && m_bit < 2) begin
        chk(sig_rd == (!ccs_en && m_frm != 0), ccs_en ? "R9 sig_rd" : "R8 sig_rd",
            sig_rd, (!ccs_en && m_frm != 0));
        if (!ccs_en && m_frm != 0)
          chk(int'(sig_addr) == m_frm + 15 * m_bit, "R8 sig_addr", sig_addr, m_frm + 15 * m_bit);
      end
    end
  end

  task automatic wait_pos(int ts, int b);
    do @(negedge clk); while (!(m_ts == ts && m_bit == b));
    #1;
  endtask

  task automatic fill_sig(int k);
    for (int i = 0; i < 32; i++) sig_mem[i] = 4'(i * 5 + k);
  endtask

  task automatic t_reset_state;
    rst_n = 0; mf_align_n = 1; ccs_en = 0; crc_en = 0; crc_bit = 0;
    rai = 0; mf_rai = 0; nat = 5'h1F; in_data = 8'hFF; sig_data = '0;
    fill_sig(3);
    repeat (4) @(negedge clk);
    chk(tx_bit == 1'b0, "R1 tx_bit", tx_bit, 0);
    chk(ts_req == 1'b1, "R1 ts_req", ts_req, 1);
    chk(req_ts == 5'd0, "R1 req_ts", req_ts, 0);
    chk(sig_rd == 1'b0, "R1 sig_rd", sig_rd, 0);
    #1 rst_n = 1;
    #2 chk(ts_req == 1'b1 && req_ts == 5'd0, "R1 after release", {ts_req, req_ts}, 6'h20);
    mon_on = 1;
  endtask

  task automatic t_cas_frames;
    repeat (2 * MF_CYC) @(negedge clk);
  endtask

  task automatic t_alarm_bits;
    wait_pos(20, 3);
    rai = 1; nat = 5'h0A; mf_rai = 1; fill_sig(9); skip = 1;
    repeat (MF_CYC + 256) @(negedge clk);
  endtask

  task automatic t_crc_bit1;
    wait_pos(20, 3);
    crc_en = 1; crc_bit = 0; skip = 1;
    repeat (MF_CYC) @(negedge clk);
    wait_pos(20, 3);
    crc_bit = 1; skip = 1;
    repeat (MF_CYC) @(negedge clk);
    wait_pos(20, 3);
    crc_en = 0; skip = 1;
    repeat (512) @(negedge clk);
  endtask

  task automatic t_ccs_mode;
    int rd_seen;
    rd_seen = 0;
    wait_pos(20, 3);
    ccs_en = 1; skip = 1;
    repeat (MF_CYC + 256) begin
      @(negedge clk);
      if (sig_rd) rd_seen++;
    end
    chk(rd_seen == 0, "R9 no reads", rd_seen, 0);
    wait_pos(20, 3);
    ccs_en = 0; skip = 1;
    repeat (MF_CYC) @(negedge clk);
  endtask

  task automatic t_mf_align;
    logic [7:0] got;
    wait_pos(9, 3);
    mf_align_n = 0;
    @(negedge clk);
    got[7] = tx_bit;
    #1 mf_align_n = 1;
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      got[i] = tx_bit;
    end
    chk(got == 8'h9B, "R10 restart slot0", got, 8'h9B);
    do @(negedge clk); while (!(m_ts == 16 && m_bit == 0));
    got[7] = tx_bit;
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      got[i] = tx_bit;
    end
    chk(got == {4'b0000, 1'b1, mf_rai, 2'b11}, "R10 frame0 slot16", got,
        {4'b0000, 1'b1, mf_rai, 2'b11});
    wait_pos(5, 2);
    mf_align_n = 0;
    begin
      int bad;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (tx_bit !== 1'b1) bad++;
      end
      chk(bad == 0, "R10 held low", bad, 0);
    end
    #1 mf_align_n = 1;
    repeat (MF_CYC) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cas_frames();
    t_alarm_bits();
    t_crc_bit1();
    t_ccs_mode();
    t_mf_align();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule